// File: doc/BRIEF.md
# Out-of-Order Scoreboard Controller

This block is the central hazard tracker for a small cluster of functional units. Decoded instructions arrive in program order, one per cycle. Each instruction carries a unit class, one destination register and two source registers. The block holds a status entry for every functional unit and a result table that records, for each register, which unit will write it next. From these two tables it decides in each cycle which unit may accept a new instruction, which may fetch its operands, and which may put its result on the result bus.

The unit set is one integer unit, two multipliers, one adder and one divider. The integer unit also serves loads and stores. Each unit is modelled as a down-counter with its own execute latency, which is a parameter. Register identifiers are six bits wide. Bit 5 selects the floating-point file (1) or the integer file (0), and bits 4:0 give the register number. Integer register 0 (id 0) means "no register": it is never tracked as pending and is never waited on. Branches never reach this block. The datapath stays outside: it copies operands and results when the matching grant is high.

Top module: `scb_ctrl`

## Requirements
- R1: After synchronous reset, all grants are low and `in_ready` is high for every class.
- R2: Issue and read-operands each take one cycle. With no hazards, the read grant comes in the cycle after the issue grant, and a unit gets exactly one read grant per issued instruction.
- R3: An instruction stalls at issue (`in_ready` low) while no unit of its class is free. A multiply goes to unit 1 when it is free, otherwise to unit 2.
- R4: An instruction whose destination (other than id 0) is still pending for an active instruction stalls at issue.
- R5: A consumer that waits on a source gets its read grant in the same cycle as the producer's write grant.
- R6: A finished unit is denied its write grant while an earlier issued, not-yet-read instruction still holds the old value of its destination as a ready source. It writes in the cycle after that reader's read grant.
- R7: A unit that receives a write grant can accept a new issue in that same cycle.
- R8: The write grant comes no earlier than LAT+1 cycles after the read grant, where LAT is the unit's latency (defaults: integer 1, multiply 4, add 2, divide 8).
- R9: Register id 0 creates neither a WAW stall as a destination nor a RAW wait as a source.
- R10: Integer and floating-point registers with the same number are tracked independently.
- R11: Grant vectors use bit 0 for integer, bits 1 and 2 for the two multipliers, bit 3 for add and bit 4 for divide. Class codes are 0 integer, 1 multiply, 2 add, 3 divide. At most one issue grant is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 2 | Unit class of the presented instruction |
| in_dst | input | 6 | Destination register id (0 = none) |
| in_src1 | input | 6 | First source register id (0 = none) |
| in_src2 | input | 6 | Second source register id (0 = none) |
| in_ready | output | 1 | The presented instruction can issue this cycle |
| issue_grant | output | 5 | Per-unit issue grant |
| read_grant | output | 5 | Per-unit read-operands grant |
| write_grant | output | 5 | Per-unit write-result grant |

## Verification
The hardest case to reach is the WAR stall. The writer has to finish while an older instruction still holds the writer's destination as a ready, unread source. That can only happen when the older instruction is held back by a different, slower operand. The stimulus builds this with three instructions. A multiply produces one source of an add. The add's other source is the destination of a fast integer operation issued just after. The bench then checks that the integer write lands exactly one cycle after the add's read, and that this read coincides with the multiply's write.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int NFU    = 5;
    localparam int UNIT_W = 3;
    localparam int REG_W  = 6;
    localparam int NREG   = 1 << REG_W;
    localparam int CNT_W  = 5;

    localparam int U_INT  = 0;
    localparam int U_MUL0 = 1;
    localparam int U_MUL1 = 2;
    localparam int U_ADD  = 3;
    localparam int U_DIV  = 4;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } fu_class_e;

    typedef logic [REG_W-1:0]  reg_id_t;
    typedef logic [UNIT_W-1:0] unit_id_t;

    typedef struct packed {
        logic             busy;
        fu_class_e        op;
        reg_id_t          fi;
        reg_id_t          fj;
        reg_id_t          fk;
        unit_id_t         qj;
        unit_id_t         qk;
        logic             qj_v;
        logic             qk_v;
        logic             rj;
        logic             rk;
        logic             rd_done;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } fu_entry_t;

    function automatic logic is_none(reg_id_t r);
        return r == '0;
    endfunction
endpackage

// File: rtl/scb_result_table.sv
module scb_result_table
    import scb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NFU-1:0]                wr_all,
    input  logic [NFU-1:0][REG_W-1:0]     fi_all,
    input  logic                          set_en,
    input  reg_id_t                       set_reg,
    input  unit_id_t                      set_unit,
    output logic [NREG-1:0]               pend,
    output logic [NREG-1:0][UNIT_W-1:0]   owner
);
    logic [NREG-1:0] clr;

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            clr[r] = 1'b0;
            for (int u = 0; u < NFU; u++) begin
                if (wr_all[u] && fi_all[u] == REG_W'(r) && owner[r] == UNIT_W'(u))
                    clr[r] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            owner <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (set_en && set_reg == REG_W'(r)) begin
                    pend[r]  <= 1'b1;
                    owner[r] <= set_unit;
                end else if (clr[r]) begin
                    pend[r]  <= 1'b0;
                end
            end
        end
    end

    assert_no_waw_R4: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !pend[set_reg]);
    assert_no_r0_R9: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !is_none(set_reg));
endmodule

// File: rtl/scb_fu_slot.sv
module scb_fu_slot
    import scb_pkg::*;
#(
    parameter int SLOT = 0,
    parameter int LAT  = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           issue_en,
    input  fu_entry_t      issue_ent,
    input  logic [NFU-1:0] wr_all,
    output fu_entry_t      ent,
    output logic           rd_go
);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LAT - 1);

    logic my_wr;
    logic j_now;
    logic k_now;

    assign my_wr = wr_all[SLOT];
    assign j_now = ent.qj_v && wr_all[ent.qj];
    assign k_now = ent.qk_v && wr_all[ent.qk];
    assign rd_go = ent.busy && !ent.rd_done && (ent.rj || j_now) && (ent.rk || k_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (issue_en) begin
            ent         <= issue_ent;
            ent.busy    <= 1'b1;
            ent.rd_done <= 1'b0;
            ent.done    <= 1'b0;
            ent.cnt     <= CNT_INIT;
        end else if (my_wr) begin
            ent <= '0;
        end else if (rd_go) begin
            ent.rd_done <= 1'b1;
            ent.rj      <= 1'b0;
            ent.rk      <= 1'b0;
            ent.qj_v    <= 1'b0;
            ent.qk_v    <= 1'b0;
        end else begin
            if (j_now) begin
                ent.rj   <= 1'b1;
                ent.qj_v <= 1'b0;
            end
            if (k_now) begin
                ent.rk   <= 1'b1;
                ent.qk_v <= 1'b0;
            end
            if (ent.rd_done && !ent.done) begin
                if (ent.cnt == '0) ent.done <= 1'b1;
                else               ent.cnt  <= ent.cnt - 1'b1;
            end
        end
    end

    assert_issue_free_R7: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> (!ent.busy || my_wr));
    assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go);
    assert_wr_after_exec_R8: assert property (@(posedge clk) disable iff (rst)
        my_wr |-> (ent.done && !$past(rd_go)));
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
    import scb_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 4,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] in_class,
    input  logic [5:0] in_dst,
    input  logic [5:0] in_src1,
    input  logic [5:0] in_src2,
    output logic       in_ready,
    output logic [4:0] issue_grant,
    output logic [4:0] read_grant,
    output logic [4:0] write_grant
);
    localparam int LATS [NFU] = '{LAT_INT, LAT_MUL, LAT_MUL, LAT_ADD, LAT_DIV};

    fu_entry_t                       ents [NFU];
    fu_entry_t                       new_ent;
    logic [NFU-1:0]                  free_now;
    logic [NFU-1:0]                  war;
    logic [NFU-1:0]                  wr;
    logic [NFU-1:0]                  rd;
    logic [NFU-1:0][REG_W-1:0]       fi_all;
    logic [NREG-1:0]                 pend;
    logic [NREG-1:0][UNIT_W-1:0]     owner;
    unit_id_t                        cand;
    logic                            waw;
    logic                            fire;

    // WAR: a finished unit waits while another active entry still has
    // its destination as a ready, unread operand.
    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            war[u] = 1'b0;
            for (int f = 0; f < NFU; f++) begin
                if (f != u && ents[f].busy && !ents[f].rd_done && !is_none(ents[u].fi) &&
                    ((ents[f].fj == ents[u].fi && ents[f].rj) ||
                     (ents[f].fk == ents[u].fi && ents[f].rk)))
                    war[u] = 1'b1;
            end
            wr[u]       = ents[u].busy && ents[u].done && !war[u];
            free_now[u] = !ents[u].busy || wr[u];
            fi_all[u]   = ents[u].fi;
        end
    end

    always_comb begin
        case (fu_class_e'(in_class))
            CLS_INT: cand = UNIT_W'(U_INT);
            CLS_MUL: cand = free_now[U_MUL0] ? UNIT_W'(U_MUL0) : UNIT_W'(U_MUL1);
            CLS_ADD: cand = UNIT_W'(U_ADD);
            default: cand = UNIT_W'(U_DIV);
        endcase
        waw      = !is_none(in_dst) && pend[in_dst];
        in_ready = free_now[cand] && !waw;
        fire     = in_valid && in_ready;
    end

    // Operand lookup; a producer writing this cycle counts as ready.
    always_comb begin
        new_ent      = '0;
        new_ent.op   = fu_class_e'(in_class);
        new_ent.fi   = in_dst;
        new_ent.fj   = in_src1;
        new_ent.fk   = in_src2;
        new_ent.qj   = owner[in_src1];
        new_ent.qk   = owner[in_src2];
        new_ent.qj_v = !is_none(in_src1) && pend[in_src1] && !wr[owner[in_src1]];
        new_ent.qk_v = !is_none(in_src2) && pend[in_src2] && !wr[owner[in_src2]];
        new_ent.rj   = !new_ent.qj_v;
        new_ent.rk   = !new_ent.qk_v;
    end

    for (genvar g = 0; g < NFU; g++) begin : g_slot
        scb_fu_slot #(.SLOT(g), .LAT(LATS[g])) u_slot (
            .clk       (clk),
            .rst       (rst),
            .issue_en  (fire && cand == UNIT_W'(g)),
            .issue_ent (new_ent),
            .wr_all    (wr),
            .ent       (ents[g]),
            .rd_go     (rd[g])
        );
    end

    scb_result_table u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_all   (wr),
        .fi_all   (fi_all),
        .set_en   (fire && !is_none(in_dst)),
        .set_reg  (in_dst),
        .set_unit (cand),
        .pend     (pend),
        .owner    (owner)
    );

    assign issue_grant = fire ? (NFU'(1) << cand) : '0;
    assign read_grant  = rd;
    assign write_grant = wr;

    assert_issue_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_grant));
    assert_write_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
        (|(write_grant & read_grant)) == 1'b0);
endmodule

// File: tb/test_scb_ctrl.sv
`timescale 1ns/1ps
module test_scb_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [5:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       in_ready;
    logic [4:0] issue_grant, read_grant, write_grant;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int rd_cyc [5];
    int wr_cyc [5];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scb_ctrl i_scb_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .issue_grant(issue_grant),
        .read_grant(read_grant), .write_grant(write_grant)
    );

    initial begin
        for (int u = 0; u < 5; u++) begin rd_cyc[u] = -1; wr_cyc[u] = -1; end
    end

    always @(negedge clk) begin
        #2;
        for (int u = 0; u < 5; u++) begin
            if (read_grant[u])  rd_cyc[u] = cyc;
            if (write_grant[u]) wr_cyc[u] = cyc;
        end
    end

    // {class, expected unit, latency}
    localparam logic [10:0] VEC [4] = '{
        {2'd0, 5'b00001, 4'd1},
        {2'd1, 5'b00010, 4'd4},
        {2'd2, 5'b01000, 4'd2},
        {2'd3, 5'b10000, 4'd8}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [5:0] d, s1, s2,
                         output int icyc, output logic [4:0] g);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_dst = d; in_src1 = s1; in_src2 = s2;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        icyc = cyc;
        g = issue_grant;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 1'b0; end
    endtask

    task automatic probe(input logic [1:0] c, input logic [5:0] d, s1, s2);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_dst = d; in_src1 = s1; in_src2 = s2;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int ic, ic2, ic3, t;
        logic [4:0] g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(issue_grant == 0 && read_grant == 0 && write_grant == 0, "R1 grants", read_grant, 0);
        for (int c = 0; c < 4; c++) begin
            in_class = 2'(c); #1;
            chk(in_ready, "R1 ready", in_ready, 1);
        end

        // R2 R8 R11: table of single instructions
        for (int v = 0; v < 4; v++) begin
            int u = 0;
            for (int b = 0; b < 5; b++) if (VEC[v][b+4]) u = b;
            issue(VEC[v][10:9], 6'd33, 6'd0, 6'd0, ic, g);
            chk(g == VEC[v][8:4], "R11 unit", g, VEC[v][8:4]);
            idle(1);
            t = 0;
            while (wr_cyc[u] <= ic && t < 50) begin @(negedge clk); t++; end
            #3;
            chk(rd_cyc[u] == ic + 1, "R2 read", rd_cyc[u] - ic, 1);
            chk(wr_cyc[u] - rd_cyc[u] == int'(VEC[v][3:0]) + 1, "R8 latency",
                wr_cyc[u] - rd_cyc[u], int'(VEC[v][3:0]) + 1);
            idle(2);
        end

        // R3 structural
        issue(2'd1, 6'd34, 6'd0, 6'd0, ic, g);
        chk(g == 5'b00010, "R3 mul0", g, 5'b00010);
        issue(2'd1, 6'd36, 6'd0, 6'd0, ic, g);
        chk(g == 5'b00100, "R3 mul1", g, 5'b00100);
        probe(2'd1, 6'd38, 6'd0, 6'd0);
        chk(!in_ready, "R3 stall", in_ready, 0);
        idle(12);

        // R4 WAW
        issue(2'd2, 6'd40, 6'd0, 6'd0, ic, g);
        probe(2'd1, 6'd40, 6'd0, 6'd0);
        chk(!in_ready, "R4 waw stall", in_ready, 0);
        idle(12);

        // R9 id 0 never pending
        issue(2'd1, 6'd0, 6'd0, 6'd0, ic, g);
        probe(2'd2, 6'd0, 6'd0, 6'd0);
        chk(in_ready, "R9 no waw", in_ready, 1);
        ic2 = cyc;
        idle(1); #3;
        chk(rd_cyc[3] == ic2 + 1, "R9 no raw", rd_cyc[3] - ic2, 1);
        idle(12);

        // R10 separate files
        issue(2'd2, 6'd37, 6'd0, 6'd0, ic, g);
        probe(2'd1, 6'd5, 6'd5, 6'd0);
        chk(in_ready, "R10 no waw", in_ready, 1);
        ic2 = cyc;
        idle(1); #3;
        chk(rd_cyc[1] == ic2 + 1, "R10 no raw", rd_cyc[1] - ic2, 1);
        idle(12);

        // R5 RAW forwarding, R6 WAR stall
        issue(2'd1, 6'd52, 6'd0, 6'd0, ic, g);
        issue(2'd2, 6'd54, 6'd52, 6'd53, ic2, g);
        issue(2'd0, 6'd53, 6'd0, 6'd0, ic3, g);
        idle(1);
        t = 0;
        while (wr_cyc[0] <= ic3 && t < 50) begin @(negedge clk); t++; end
        #3;
        chk(rd_cyc[3] == wr_cyc[1], "R5 read with producer write", rd_cyc[3], wr_cyc[1]);
        chk(wr_cyc[0] == rd_cyc[3] + 1, "R6 war write", wr_cyc[0], rd_cyc[3] + 1);
        chk(wr_cyc[0] > ic3 + 3, "R6 delayed", wr_cyc[0] - ic3, 5);
        idle(12);

        // R7 same-cycle reissue
        issue(2'd0, 6'd1, 6'd0, 6'd0, ic, g);
        issue(2'd0, 6'd2, 6'd0, 6'd0, ic2, g);
        chk(write_grant[0] && g == 5'b00001, "R7 reissue", write_grant, 1);
        chk(ic2 == ic + 3, "R7 cycle", ic2 - ic, 3);
        idle(8);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule